// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits between a qualified word-write source and the page write controller of a four-bank non-volatile word memory. Every accepted write event (17-bit address, 16-bit data, one-hot bank select) is decoded against a small set of keyed command words that target two fixed addresses. A three-word keyed sequence opens a write window for one bank and arms its protect bit. A six-word keyed sequence opens a window and arms clearing of that bit. Each bank keeps its own protect bit. A new bit value is committed only when the page write controller signals that the write period has ended.

Ordinary data writes are forwarded to the page write controller as a one-cycle strobe when the target bank is unprotected or inside an open window. A write to a protected bank outside a window is dropped. The block still requests a write-period timer run for it, so the memory appears busy for the normal cycle time. A power-cycle input aborts any sequence or window in progress and keeps the protect bits. Only the chip-level reset clears them.

Top module: `wp_sequencer`

## Requirements
- R1: While reset is asserted, and after its release, all protect flags are 0 and both strobes are low until a write or end-of-period event occurs.
- R2: A data write to a bank whose protect flag is 0 produces `pass_stb` high for exactly the one cycle after the write cycle, with `timer_req` low.
- R3: The enable sequence is three writes in order: data 16'hAAAA at address 17'h05555, then 16'h5555 at 17'h02AAA, then 16'hA0A0 at 17'h05555. None of these words is passed. The last word pulses `timer_req` one cycle later and opens a window for the bank selected on that word. Data writes to that bank pass while the window is open. At the next `wp_done`, the bank's flag becomes 1.
- R4: The enable sequence followed directly by `wp_done`, with no data words in between, still sets the bank's flag.
- R5: A data write to a protected bank outside its window is not passed. It pulses `timer_req` one cycle later and leaves the flags unchanged.
- R6: The disable sequence is six writes in order: 16'hAAAA at 17'h05555, 16'h5555 at 17'h02AAA, 16'h8080 at 17'h05555, 16'hAAAA at 17'h05555, 16'h5555 at 17'h02AAA, 16'h2020 at 17'h05555. None of these words is passed. The last word pulses `timer_req` and opens a window for its bank. Data writes to that bank then pass. At the next `wp_done`, that bank's flag becomes 0.
- R7: A write that does not match the next expected word of a sequence in progress returns the sequencer to idle. That write is judged as an ordinary data write under the current flags.
- R8: Each bank's flag changes only through a sequence completed on that bank. Writes to other banks are judged against their own flags.
- R9: `pwr_cycle` leaves all flags unchanged, aborts any sequence or open window, and a write presented in the same cycle produces neither strobe.
- R10: `wp_done` with no open window changes no flag. Flags change only in the cycle after `wp_done`.
- R11: `pass_stb` and `timer_req` are never high together, and each is high only in the cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_cycle | input | 1 | Supply-transition event; aborts sequences, keeps flags |
| wr_valid | input | 1 | One-cycle qualified word-write event |
| wr_addr | input | 17 | Word address of the write |
| wr_data | input | 16 | Data word of the write |
| bank_sel | input | 4 | One-hot bank select of the write |
| wp_done | input | 1 | End of the current write period from the page write controller |
| pass_stb | output | 1 | Forward this data write to the page write controller |
| timer_req | output | 1 | Run the write-period timer without writing data |
| prot_flags | output | 4 | Per-bank software protect state |

## Verification
The assertions assume that `bank_sel` is one-hot whenever `wr_valid` is high. They also assume that `wr_valid` and `wp_done` never arrive in the same cycle, because the order between a last window write and the end of the period is left to the surrounding controller. The random stimulus always picks a single bank index for a write. It issues a write, an end of period and a power-cycle event as separate operations, and only pairs `pwr_cycle` with a write. The address and data are biased toward the two keyed addresses and the five command codes, so that partial, broken and completed sequences all occur among the directed cases.

// File: rtl/wpseq_pkg.sv
package wpseq_pkg;
  localparam int DW = 16;

  localparam logic [16:0] ADR_HI = 17'h05555;
  localparam logic [16:0] ADR_LO = 17'h02AAA;
  localparam logic [DW-1:0] D_KEY1 = 16'hAAAA;
  localparam logic [DW-1:0] D_KEY2 = 16'h5555;
  localparam logic [DW-1:0] D_EN   = 16'hA0A0;
  localparam logic [DW-1:0] D_DIS  = 16'h8080;
  localparam logic [DW-1:0] D_FIN  = 16'h2020;

  typedef enum logic [2:0] {
    TK_NONE, TK_KEY1, TK_KEY2, TK_EN, TK_DIS, TK_FIN
  } tok_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5, ST_OPEN
  } seq_st_e;
endpackage

// File: rtl/wpseq_tok.sv
module wpseq_tok
  import wpseq_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output tok_e          tok
);
  localparam logic [AW-1:0] A_HI = AW'(ADR_HI);
  localparam logic [AW-1:0] A_LO = AW'(ADR_LO);

  always_comb begin
    tok = TK_NONE;
    if (addr == A_HI) begin
      unique case (data)
        D_KEY1:  tok = TK_KEY1;
        D_EN:    tok = TK_EN;
        D_DIS:   tok = TK_DIS;
        D_FIN:   tok = TK_FIN;
        default: tok = TK_NONE;
      endcase
    end else if (addr == A_LO && data == D_KEY2) begin
      tok = TK_KEY2;
    end
  end
endmodule

// File: rtl/wpseq_fsm.sv
module wpseq_fsm
  import wpseq_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_cycle,
  input  logic             wr_valid,
  input  tok_e             tok,
  input  logic [NBANK-1:0] bank_sel,
  input  logic             wp_done,
  output seq_st_e          st,
  output logic             is_cmd,
  output logic             seq_done,
  output logic             commit,
  output logic [NBANK-1:0] win_bank,
  output logic             win_set
);
  seq_st_e          st_q, st_d;
  logic [NBANK-1:0] bank_q, bank_d;
  logic             set_q, set_d;

  always_comb begin
    st_d     = st_q;
    bank_d   = bank_q;
    set_d    = set_q;
    is_cmd   = 1'b0;
    seq_done = 1'b0;
    commit   = 1'b0;
    if (pwr_cycle) begin
      st_d = ST_IDLE;
    end else if (st_q == ST_OPEN && wp_done) begin
      commit = 1'b1;
      st_d   = ST_IDLE;
    end else if (wr_valid) begin
      st_d = ST_IDLE;
      unique case (st_q)
        ST_IDLE: if (tok == TK_KEY1) begin st_d = ST_K1; is_cmd = 1'b1; end
        ST_K1:   if (tok == TK_KEY2) begin st_d = ST_K2; is_cmd = 1'b1; end
        ST_K2: begin
          if (tok == TK_EN) begin
            st_d = ST_OPEN; set_d = 1'b1; bank_d = bank_sel;
            is_cmd = 1'b1; seq_done = 1'b1;
          end else if (tok == TK_DIS) begin
            st_d = ST_K3; is_cmd = 1'b1;
          end
        end
        ST_K3:   if (tok == TK_KEY1) begin st_d = ST_K4; is_cmd = 1'b1; end
        ST_K4:   if (tok == TK_KEY2) begin st_d = ST_K5; is_cmd = 1'b1; end
        ST_K5: begin
          if (tok == TK_FIN) begin
            st_d = ST_OPEN; set_d = 1'b0; bank_d = bank_sel;
            is_cmd = 1'b1; seq_done = 1'b1;
          end
        end
        ST_OPEN: st_d = ST_OPEN;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bank_q <= '0;
      set_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bank_q <= bank_d;
      set_q  <= set_d;
    end
  end

  assign st       = st_q;
  assign win_bank = bank_q;
  assign win_set  = set_q;
endmodule

// File: rtl/wpseq_gate.sv
module wpseq_gate #(
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_cycle,
  input  logic             wr_valid,
  input  logic [NBANK-1:0] bank_sel,
  input  logic             is_cmd,
  input  logic             seq_done,
  input  logic             win_open,
  input  logic [NBANK-1:0] win_bank,
  input  logic             win_set,
  input  logic             commit,
  output logic [NBANK-1:0] prot,
  output logic             pass_stb,
  output logic             timer_req
);
  logic [NBANK-1:0] prot_q, prot_d;
  logic             pass_q, pass_d, treq_q, treq_d;
  logic             allow;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_comb prot_d[b] = (commit && win_bank[b]) ? win_set : prot_q[b];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prot_q[b] <= 1'b0;
      else        prot_q[b] <= prot_d[b];
    end
  end

  always_comb begin
    allow  = |(bank_sel & (~prot_q | (win_open ? win_bank : '0)));
    pass_d = wr_valid && !pwr_cycle && !is_cmd && allow;
    treq_d = wr_valid && !pwr_cycle && ((!is_cmd && !allow) || seq_done);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q <= 1'b0;
      treq_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      treq_q <= treq_d;
    end
  end

  assign prot      = prot_q;
  assign pass_stb  = pass_q;
  assign timer_req = treq_q;
endmodule

// File: rtl/wp_sequencer.sv
module wp_sequencer
  import wpseq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_cycle,
  input  logic             wr_valid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NBANK-1:0] bank_sel,
  input  logic             wp_done,
  output logic             pass_stb,
  output logic             timer_req,
  output logic [NBANK-1:0] prot_flags
);
  logic [1:0]       rst_sync;
  logic             core_rst_n;
  tok_e             tok;
  seq_st_e          seq_st;
  logic             is_cmd, seq_done, commit, win_set;
  logic [NBANK-1:0] win_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  wpseq_tok #(.AW(AW)) u_tok (
    .addr (wr_addr),
    .data (wr_data),
    .tok  (tok)
  );

  wpseq_fsm #(.NBANK(NBANK)) u_fsm (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .pwr_cycle (pwr_cycle),
    .wr_valid  (wr_valid),
    .tok       (tok),
    .bank_sel  (bank_sel),
    .wp_done   (wp_done),
    .st        (seq_st),
    .is_cmd    (is_cmd),
    .seq_done  (seq_done),
    .commit    (commit),
    .win_bank  (win_bank),
    .win_set   (win_set)
  );

  wpseq_gate #(.NBANK(NBANK)) u_gate (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .pwr_cycle (pwr_cycle),
    .wr_valid  (wr_valid),
    .bank_sel  (bank_sel),
    .is_cmd    (is_cmd),
    .seq_done  (seq_done),
    .win_open  (seq_st == ST_OPEN),
    .win_bank  (win_bank),
    .win_set   (win_set),
    .commit    (commit),
    .prot      (prot_flags),
    .pass_stb  (pass_stb),
    .timer_req (timer_req)
  );
endmodule

// File: rtl/wp_sequencer_chk.sv
module wp_sequencer_chk
  import wpseq_pkg::*;
#(
  parameter int AW    = 17,
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_cycle,
  input logic             wr_valid,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [NBANK-1:0] bank_sel,
  input logic             wp_done,
  input logic             pass_stb,
  input logic             timer_req,
  input logic [NBANK-1:0] prot_flags,
  input seq_st_e          seq_st
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> prot_flags == '0);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_stb && timer_req));

  // R11
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !pass_stb && !timer_req);

  // R9
  pwr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cycle |=> $stable(prot_flags) && !pass_stb && !timer_req);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_done |=> $stable(prot_flags));

  // R3
  cmd_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !pwr_cycle && seq_st == ST_IDLE && wr_addr == AW'(ADR_HI)
      && wr_data == D_KEY1 |=> !pass_stb && !timer_req);

  // R8
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $onehot0(bank_sel) && bank_sel != '0);
endmodule

bind wp_sequencer wp_sequencer_chk #(.AW(AW), .NBANK(NBANK)) i_chk (.*);

// File: tb/test_wp_sequencer.sv
`timescale 1ns/1ps
module test_wp_sequencer;
  logic        clk = 1'b0;
  logic        rst_n, pwr_cycle, wr_valid, wp_done;
  logic [16:0] wr_addr;
  logic [15:0] wr_data;
  logic [3:0]  bank_sel;
  logic        pass_stb, timer_req;
  logic [3:0]  prot_flags;

  int checks = 0, errors = 0;
  bit finished = 0;

  int         m_st = 0;
  int         m_bank = 0;
  logic       m_set = 1'b0;
  logic [3:0] m_prot = 4'h0;

  always #2 clk = ~clk;

  wp_sequencer i_wp_sequencer (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .bank_sel(bank_sel),
    .wp_done(wp_done), .pass_stb(pass_stb), .timer_req(timer_req),
    .prot_flags(prot_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 none, 1 first key, 2 second key, 3 enable, 4 disable, 5 finish
  function automatic int tok_of(input logic [16:0] a, input logic [15:0] d);
    if (a == 17'h05555) begin
      if (d == 16'hAAAA) return 1;
      if (d == 16'hA0A0) return 3;
      if (d == 16'h8080) return 4;
      if (d == 16'h2020) return 5;
    end else if (a == 17'h02AAA && d == 16'h5555) return 2;
    return 0;
  endfunction

  task automatic op(input logic wv, input int b, input logic [16:0] a,
                    input logic [15:0] d, input logic dn, input logic pc,
                    input string tag);
    logic ep = 1'b0, et = 1'b0, cmd = 1'b0, fin = 1'b0, allow;
    int   t = tok_of(a, d);
    @(negedge clk);
    wr_valid = wv; bank_sel = 4'b1 << b; wr_addr = a; wr_data = d;
    wp_done = dn; pwr_cycle = pc;
    if (pc) m_st = 0;
    else if (m_st == 6 && dn) begin m_prot[m_bank] = m_set; m_st = 0; end
    else if (wv) begin
      allow = !m_prot[b] || (m_st == 6 && m_bank == b);
      case (m_st)
        0: if (t == 1) begin m_st = 1; cmd = 1; end
        1: if (t == 2) begin m_st = 2; cmd = 1; end else m_st = 0;
        2: if (t == 3) begin m_st = 6; m_set = 1; m_bank = b; cmd = 1; fin = 1; end
           else if (t == 4) begin m_st = 3; cmd = 1; end else m_st = 0;
        3: if (t == 1) begin m_st = 4; cmd = 1; end else m_st = 0;
        4: if (t == 2) begin m_st = 5; cmd = 1; end else m_st = 0;
        5: if (t == 5) begin m_st = 6; m_set = 0; m_bank = b; cmd = 1; fin = 1; end
           else m_st = 0;
        default: m_st = 6;
      endcase
      ep = !cmd && allow;
      et = (!cmd && !allow) || fin;
    end
    @(posedge clk); #1;
    chk({tag, " pass"}, 32'(pass_stb), 32'(ep));
    chk({tag, " treq"}, 32'(timer_req), 32'(et));
    chk({tag, " prot"}, 32'(prot_flags), 32'(m_prot));
    chk("R11 excl", 32'(pass_stb && timer_req), 32'd0);
    wr_valid = 0; wp_done = 0; pwr_cycle = 0;
  endtask

  task automatic wr(input int b, input logic [16:0] a, input logic [15:0] d, input string tag);
    op(1'b1, b, a, d, 1'b0, 1'b0, tag);
  endtask

  task automatic seq_en(input int b, input string tag);
    wr(b, 17'h05555, 16'hAAAA, tag);
    wr(b, 17'h02AAA, 16'h5555, tag);
    wr(b, 17'h05555, 16'hA0A0, tag);
  endtask

  task automatic seq_dis(input int b, input string tag);
    wr(b, 17'h05555, 16'hAAAA, tag);
    wr(b, 17'h02AAA, 16'h5555, tag);
    wr(b, 17'h05555, 16'h8080, tag);
    wr(b, 17'h05555, 16'hAAAA, tag);
    wr(b, 17'h02AAA, 16'h5555, tag);
    wr(b, 17'h05555, 16'h2020, tag);
  endtask

  task automatic end_period(input string tag);
    op(1'b0, 0, 17'h0, 16'h0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    rst_n = 0; pwr_cycle = 0; wr_valid = 0; wp_done = 0;
    wr_addr = '0; wr_data = '0; bank_sel = 4'b0001;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 prot in reset", 32'(prot_flags), 0);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    chk("R1 prot", 32'(prot_flags), 0);
    chk("R1 strobes", 32'({pass_stb, timer_req}), 0);

    wr(0, 17'h00123, 16'h1234, "R2");
    wr(3, 17'h05555, 16'h0001, "R2");
    seq_en(1, "R3");
    wr(1, 17'h00200, 16'hBEEF, "R3 window");
    wr(1, 17'h00201, 16'hCAFE, "R3 window");
    end_period("R3");
    wr(1, 17'h00300, 16'h0F0F, "R5");
    wr(0, 17'h00300, 16'h0F0F, "R8");
    seq_en(2, "R4");
    end_period("R4");
    wr(1, 17'h05555, 16'hAAAA, "R7");
    wr(1, 17'h00100, 16'h1234, "R7");
    wr(0, 17'h05555, 16'hAAAA, "R7");
    wr(0, 17'h02AAA, 16'h5555, "R7");
    wr(0, 17'h02AAA, 16'h5555, "R7");
    wr(1, 17'h05555, 16'hAAAA, "R9");
    wr(1, 17'h02AAA, 16'h5555, "R9");
    op(1'b0, 0, 17'h0, 16'h0, 1'b0, 1'b1, "R9");
    wr(1, 17'h05555, 16'hA0A0, "R9");
    op(1'b1, 0, 17'h00010, 16'h5A5A, 1'b0, 1'b1, "R9");
    seq_en(3, "R9");
    op(1'b0, 0, 17'h0, 16'h0, 1'b0, 1'b1, "R9");
    end_period("R10");
    seq_dis(1, "R6");
    wr(1, 17'h00040, 16'h4444, "R6");
    end_period("R6");
    wr(1, 17'h00041, 16'h4545, "R6");

    for (int i = 0; i < 1500; i++) begin
      int k = int'($urandom_range(0, 9));
      int b = int'($urandom_range(0, 3));
      logic [16:0] a;
      logic [15:0] d;
      case ($urandom_range(0, 2))
        0: a = 17'h05555;
        1: a = 17'h02AAA;
        default: a = 17'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0: d = 16'hAAAA; 1: d = 16'h5555; 2: d = 16'hA0A0;
        3: d = 16'h8080; 4: d = 16'h2020;
        default: d = 16'($urandom);
      endcase
      if (k < 5) wr(b, a, d, "R2 rnd");
      else if (k == 5) seq_en(b, "R3 rnd");
      else if (k == 6) seq_dis(b, "R6 rnd");
      else if (k == 7) end_period("R10 rnd");
      else if (k == 8) op(1'b1, b, a, d, 1'b0, 1'b1, "R9 rnd");
      else wr(b, 17'($urandom), 16'($urandom), "R8 rnd");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule